// File: doc/BRIEF.md
# Memory Cycle Type Classifier

This block sits between a 32-bit processor core and its memory system. It gives every bus cycle a two-bit type label: non-sequential, sequential, internal or coprocessor register transfer. A memory request is labelled sequential when it continues on from the memory access just before it, so a memory controller can use a cheaper burst-style access instead of a full random access. The block also registers the transfer size and direction for each cycle.

The address bus can be driven with one of two timings. In pipelined mode the address of a cycle appears one clock before that cycle's type, size and direction. This gives a DRAM controller a clock of early warning. In de-pipelined mode the address appears in the same clock as the rest of the cycle, which suits SRAM or ROM. The mode pin is captured while reset is asserted and then held fixed.

Each request presented on the inputs in one clock becomes the bus cycle of the next clock.

Top module: `mem_cycle_classifier`

## Requirements
- R1: The cycle code on `cyc_type` is 00 non-sequential, 01 sequential, 10 internal and 11 coprocessor. A request sampled at one rising edge sets the code seen for the whole of the following clock.
- R2: A word request (size 10) is sequential when the cycle before it was a memory cycle and its address equals that cycle's address, or that address plus 4.
- R3: A halfword request (size 01) is sequential when the cycle before it was a memory cycle and its address equals that cycle's address, or that address plus 2.
- R4: A byte request (size 00) is sequential only when it repeats the previous memory address exactly. Byte address plus 1 is non-sequential.
- R5: A memory request at any other address is non-sequential. This includes a word request at plus 2 and a backward step.
- R6: The first memory request after reset is non-sequential. So is the first memory request after an internal, idle or coprocessor cycle.
- R7: An internal cycle (code 10) results from any of these:
  - `req_valid` low;
  - `req_kind` 01 (internal);
  - the unused kind 11.

  During an internal cycle `bus_write` is 0, while `bus_size` and the address bus hold their values.
- R8: `req_kind` 10 gives a coprocessor cycle (code 11). It carries the requested size and direction, and the address bus holds the last memory address.
- R9: Memory request kind is 00. Sizes are encoded 00 byte, 01 halfword and 10 word. `bus_size` and `bus_write` (1 = write) appear in the same clock as the cycle's code.
- R10: In de-pipelined mode (mode pin 0), `bus_addr` shows a memory cycle's address in the same clock as its code. It holds that address through later non-memory cycles.
- R11: In pipelined mode (mode pin 1), `bus_addr` shows a memory request's address in the clock in which the request is presented, one clock ahead of its code. During non-memory requests it shows the last memory address.
- R12: `addr_pipe_en` is sampled only while `rst_n` is low. Changing it after reset has no effect on address timing.
- R13: After reset, `cyc_type` is 10, `bus_write` is 0 and `bus_size` is 10. In de-pipelined mode `bus_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_pipe_en | input | 1 | Address timing select: 1 pipelined, 0 de-pipelined; sampled during reset |
| req_valid | input | 1 | Request present this clock |
| req_kind | input | 2 | 00 memory, 01 internal, 10 coprocessor, 11 treated as internal |
| req_addr | input | 32 | Byte address of the request |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| req_write | input | 1 | 1 write, 0 read |
| cyc_type | output | 2 | Cycle code of the current bus cycle |
| bus_addr | output | 32 | Address bus |
| bus_size | output | 2 | Transfer size of the current bus cycle |
| bus_write | output | 1 | Transfer direction of the current bus cycle |

## Verification
Several rules are checked by assertions on every cycle:
- a sequential label only ever follows a memory cycle;
- word and byte sequential cycles keep the allowed address steps;
- internal cycles never signal a write;
- the first cycle after reset is never sequential;
- the captured mode never moves;
- in pipelined mode the address led the cycle by one clock.

Only the bench scenarios show the rest:
- that each near-miss address yields non-sequential, such as byte plus 1, word plus 2 or halfword plus 4;
- that coprocessor and idle cycles break a run;
- that toggling the mode pin after reset leaves the timing unchanged.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    typedef enum logic [1:0] {
        CT_NSEQ = 2'b00,
        CT_SEQ  = 2'b01,
        CT_INTL = 2'b10,
        CT_COPR = 2'b11
    } cyc_type_e;

    typedef enum logic [1:0] {
        RK_MEM  = 2'b00,
        RK_INTL = 2'b01,
        RK_COPR = 2'b10,
        RK_RSVD = 2'b11
    } req_kind_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

endpackage

// File: rtl/mcc_seq_cmp.sv
module mcc_seq_cmp
    import mcc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] prev_addr,
    input  logic [1:0]        cur_size,
    input  logic              prev_mem,
    output logic              is_seq
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int HALF_BYTES = WORD_BYTES / 2;
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] HALF_STEP = ADDR_W'(HALF_BYTES);

    logic [ADDR_W-1:0] step;
    logic              step_ok;
    logic              same_ok;

    always_comb begin
        case (cur_size)
            SZ_WORD: step = WORD_STEP;
            SZ_HALF: step = HALF_STEP;
            default: step = '0;
        endcase
        same_ok = (cur_addr == prev_addr);
        step_ok = (step != '0) && (cur_addr == prev_addr + step);
        is_seq  = prev_mem && (same_ok || step_ok);
    end

endmodule

// File: rtl/mcc_cycle_reg.sv
module mcc_cycle_reg
    import mcc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pin,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              is_seq,
    output logic [1:0]        ctype_q,
    output logic [1:0]        size_q,
    output logic              write_q,
    output logic [ADDR_W-1:0] last_addr_q,
    output logic              prev_mem_q,
    output logic              pipe_mode_q
);
    typedef struct packed {
        cyc_type_e         ctype;
        logic [1:0]        size;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic              prev_mem;
        logic              pmode;
    } state_t;

    state_t st_d, st_q;
    logic   is_mem, is_copr;

    always_comb begin
        is_mem  = req_valid && (req_kind == RK_MEM);
        is_copr = req_valid && (req_kind == RK_COPR);
        st_d    = st_q;
        if (is_mem) begin
            st_d.ctype    = is_seq ? CT_SEQ : CT_NSEQ;
            st_d.size     = req_size;
            st_d.wr       = req_write;
            st_d.addr     = req_addr;
            st_d.prev_mem = 1'b1;
        end else if (is_copr) begin
            st_d.ctype    = CT_COPR;
            st_d.size     = req_size;
            st_d.wr       = req_write;
            st_d.prev_mem = 1'b0;
        end else begin
            st_d.ctype    = CT_INTL;
            st_d.wr       = 1'b0;
            st_d.prev_mem = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctype    <= CT_INTL;
            st_q.size     <= SZ_WORD;
            st_q.wr       <= 1'b0;
            st_q.addr     <= '0;
            st_q.prev_mem <= 1'b0;
            st_q.pmode    <= mode_pin;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctype_q     = st_q.ctype;
    assign size_q      = st_q.size;
    assign write_q     = st_q.wr;
    assign last_addr_q = st_q.addr;
    assign prev_mem_q  = st_q.prev_mem;
    assign pipe_mode_q = st_q.pmode;

    // R12
    mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(pipe_mode_q));

    // R8
    copr_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(req_kind) == RK_COPR)
        |-> (ctype_q == CT_COPR && !prev_mem_q));

endmodule

// File: rtl/mcc_addr_drive.sv
module mcc_addr_drive
    import mcc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              pipe_mode,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] last_addr,
    output logic [ADDR_W-1:0] bus_addr
);
    logic mem_now;

    always_comb begin
        mem_now = req_valid && (req_kind == RK_MEM);
        if (pipe_mode && mem_now) bus_addr = req_addr;
        else                      bus_addr = last_addr;
    end

endmodule

// File: rtl/mem_cycle_classifier.sv
module mem_cycle_classifier
    import mcc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_pipe_en,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    output logic [1:0]        cyc_type,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic              bus_write
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(DATA_W / 8);

    logic              is_seq;
    logic [ADDR_W-1:0] last_addr;
    logic              prev_mem;
    logic              pipe_mode;

    mcc_seq_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .cur_addr  (req_addr),
        .prev_addr (last_addr),
        .cur_size  (req_size),
        .prev_mem  (prev_mem),
        .is_seq    (is_seq)
    );

    mcc_cycle_reg #(.ADDR_W(ADDR_W)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_pin    (addr_pipe_en),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_write   (req_write),
        .is_seq      (is_seq),
        .ctype_q     (cyc_type),
        .size_q      (bus_size),
        .write_q     (bus_write),
        .last_addr_q (last_addr),
        .prev_mem_q  (prev_mem),
        .pipe_mode_q (pipe_mode)
    );

    mcc_addr_drive #(.ADDR_W(ADDR_W)) u_addr (
        .pipe_mode (pipe_mode),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .last_addr (last_addr),
        .bus_addr  (bus_addr)
    );

    // R6
    seq_after_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CT_SEQ) |-> ($past(cyc_type) == CT_NSEQ || $past(cyc_type) == CT_SEQ));

    // R6
    first_not_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cyc_type != CT_SEQ));

    // R7
    intl_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CT_INTL) |-> !bus_write);

    // R2
    word_seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && cyc_type == CT_SEQ && bus_size == SZ_WORD)
        |-> (bus_addr == $past(bus_addr) || bus_addr == $past(bus_addr) + WORD_STEP));

    // R4
    byte_seq_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && cyc_type == CT_SEQ && bus_size == SZ_BYTE)
        |-> (bus_addr == $past(bus_addr)));

    // R11
    pipe_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pipe_mode && (cyc_type == CT_NSEQ || cyc_type == CT_SEQ))
        |-> ($past(bus_addr) == last_addr));

endmodule

// File: tb/mem_cycle_classifier_bench.sv
`timescale 1ns/1ps
module mem_cycle_classifier_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        addr_pipe_en;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic        req_write;
    logic [1:0]  cyc_type;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic        bus_write;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [1:0] K_MEM = 2'b00, K_INT = 2'b01, K_COP = 2'b10, K_RSV = 2'b11;
    localparam logic [1:0] S_B = 2'b00, S_H = 2'b01, S_W = 2'b10;
    localparam logic [1:0] T_NS = 2'b00, T_SQ = 2'b01, T_IN = 2'b10, T_CP = 2'b11;

    always #4 clk = ~clk;

    mem_cycle_classifier u_mem_cycle_classifier (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_pipe_en (addr_pipe_en),
        .req_valid    (req_valid),
        .req_kind     (req_kind),
        .req_addr     (req_addr),
        .req_size     (req_size),
        .req_write    (req_write),
        .cyc_type     (cyc_type),
        .bus_addr     (bus_addr),
        .bus_size     (bus_size),
        .bus_write    (bus_write)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        rst_n        = 1'b0;
        addr_pipe_en = mode;
        req_valid    = 1'b0;
        req_kind     = K_MEM;
        req_addr     = '0;
        req_size     = S_W;
        req_write    = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive a request at a falling edge, let it be registered, return at the next falling edge
    task automatic put(input logic v, input logic [1:0] k, input logic [31:0] a, input logic [1:0] s, input logic w);
        req_valid = v; req_kind = k; req_addr = a; req_size = s; req_write = w;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cyc(input string req, input logic [1:0] et, input logic [1:0] es, input logic ew, input logic [31:0] ea);
        chk(req, "cyc_type", 32'(cyc_type), 32'(et));
        chk(req, "bus_size", 32'(bus_size), 32'(es));
        chk(req, "bus_write", 32'(bus_write), 32'(ew));
        chk(req, "bus_addr", bus_addr, ea);
    endtask

    task automatic t_reset_state;
        do_reset(1'b0);
        cyc("R13", T_IN, S_W, 1'b0, 32'h0);
    endtask

    task automatic t_word_run;
        put(1, K_MEM, 32'h100, S_W, 0); cyc("R6", T_NS, S_W, 0, 32'h100);
        put(1, K_MEM, 32'h104, S_W, 0); cyc("R2", T_SQ, S_W, 0, 32'h104);
        put(1, K_MEM, 32'h104, S_W, 0); cyc("R2", T_SQ, S_W, 0, 32'h104);
        put(1, K_MEM, 32'h10C, S_W, 0); cyc("R5", T_NS, S_W, 0, 32'h10C);
        put(1, K_MEM, 32'h108, S_W, 0); cyc("R5", T_NS, S_W, 0, 32'h108);
    endtask

    task automatic t_half_run;
        put(1, K_MEM, 32'h200, S_H, 0); cyc("R5", T_NS, S_H, 0, 32'h200);
        put(1, K_MEM, 32'h202, S_H, 0); cyc("R3", T_SQ, S_H, 0, 32'h202);
        put(1, K_MEM, 32'h206, S_H, 0); cyc("R5", T_NS, S_H, 0, 32'h206);
        put(1, K_MEM, 32'h300, S_W, 0); cyc("R5", T_NS, S_W, 0, 32'h300);
        put(1, K_MEM, 32'h302, S_W, 0); cyc("R5", T_NS, S_W, 0, 32'h302);
    endtask

    task automatic t_byte_run;
        put(1, K_MEM, 32'h400, S_B, 1); cyc("R9", T_NS, S_B, 1, 32'h400);
        put(1, K_MEM, 32'h401, S_B, 0); cyc("R4", T_NS, S_B, 0, 32'h401);
        put(1, K_MEM, 32'h401, S_B, 0); cyc("R4", T_SQ, S_B, 0, 32'h401);
    endtask

    task automatic t_internal;
        put(1, K_MEM, 32'h500, S_W, 1); cyc("R9", T_NS, S_W, 1, 32'h500);
        put(0, K_MEM, 32'h504, S_B, 1); cyc("R7", T_IN, S_W, 0, 32'h500);
        put(1, K_MEM, 32'h504, S_W, 0); cyc("R6", T_NS, S_W, 0, 32'h504);
        put(1, K_INT, 32'h508, S_H, 1); cyc("R7", T_IN, S_W, 0, 32'h504);
        put(1, K_RSV, 32'h508, S_H, 1); cyc("R7", T_IN, S_W, 0, 32'h504);
        put(1, K_MEM, 32'h508, S_W, 0); cyc("R6", T_NS, S_W, 0, 32'h508);
    endtask

    task automatic t_copro;
        put(1, K_MEM, 32'h600, S_W, 0); cyc("R10", T_NS, S_W, 0, 32'h600);
        put(1, K_COP, 32'h604, S_H, 1); cyc("R8", T_CP, S_H, 1, 32'h600);
        put(1, K_MEM, 32'h604, S_W, 0); cyc("R6", T_NS, S_W, 0, 32'h604);
    endtask

    task automatic t_pipelined;
        do_reset(1'b1);
        addr_pipe_en = 1'b0;
        req_valid = 1; req_kind = K_MEM; req_addr = 32'h700; req_size = S_W; req_write = 0;
        #1 chk("R11", "early addr", bus_addr, 32'h700);
        chk("R11", "type before edge", 32'(cyc_type), 32'(T_IN));
        @(posedge clk); @(negedge clk);
        chk("R1", "cyc_type", 32'(cyc_type), 32'(T_NS));
        req_addr = 32'h704;
        #1 chk("R12", "early addr kept", bus_addr, 32'h704);
        @(posedge clk); @(negedge clk);
        chk("R2", "cyc_type", 32'(cyc_type), 32'(T_SQ));
        req_valid = 0;
        #1 chk("R11", "held addr", bus_addr, 32'h704);
        @(posedge clk); @(negedge clk);
        chk("R7", "cyc_type", 32'(cyc_type), 32'(T_IN));
    endtask

    task automatic t_depipe_locked;
        do_reset(1'b0);
        addr_pipe_en = 1'b1;
        req_valid = 1; req_kind = K_MEM; req_addr = 32'h800; req_size = S_W; req_write = 0;
        #1 chk("R12", "no early addr", bus_addr, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R10", "same-clock addr", bus_addr, 32'h800);
        chk("R1", "cyc_type", 32'(cyc_type), 32'(T_NS));
        req_valid = 0;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        t_reset_state();
        t_word_run();
        t_half_run();
        t_byte_run();
        t_internal();
        t_copro();
        t_pipelined();
        t_depipe_locked();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule